// File: doc/BRIEF.md
# Bus Master Termination and Retry Sequencer

This block is the part of a parallel-bus master that finishes a burst. The master holds the bus and presents a frame signal and a ready-to-send signal. The block watches three target replies: ready, stop and select. From them it decides how the burst ends. There are three endings:

- **Normal completion.** The last word is moved.
- **Disconnect.** The target stops the burst while words are still left. The block releases the bus, waits a fixed number of clocks, asks for the bus again and restarts at the first word that was not moved.
- **Target abort.** The target drops select while it asserts stop. The block does not try again. It raises a sticky fatal error and gives a one-clock pulse that the surrounding logic uses to return its control/status registers to their stop-reset values. Configuration registers are not in this block and are not touched.

Every ending follows the same release order. Frame drops first. Ready-to-send drops one clock later. The block stops driving the bus one clock after that. A retry counter limits how many disconnects in a row may pass with no progress. Once that limit is used up, the block reports a retry timeout and does not ask for the bus again.

All bus signals here are active high. Inversion to the electrical polarity happens at the pads. The data path is reduced to a word address and a count of words left. The address moves on by a fixed number of bytes for each word that is moved.

Top module: `pmt_top`

## Requirements
- R1: While reset is held and after it is released, req, frame, irdy, bus_drive, done, csr_clear, fatal_err and retry_tmo are all 0.
- R2: A start pulse with word_count not zero, taken in idle, sets req one clock later. After the edge that samples gnt high, the next cycle is the address phase: frame=1, irdy=0, bus_drive=1, req=0, and next_addr holds the address of the next word to move. The cycle after that has frame=1 and irdy=1.
- R3: A data phase completes on an edge where the block is in a data phase (frame=1, irdy=1) and samples trdy=1 and devsel=1. next_addr then grows by exactly STEP_BYTES (default 4). No other edge changes it while the bus is driven.
- R4: Call E the edge that samples a terminating reply. A terminating reply is stop, or the completion of the last word. After E: frame=0, irdy=1, bus_drive=1. After E+1: irdy=0, bus_drive=1. After E+2: bus_drive=0.
- R5: A disconnect leaves words still to move. It is stop=1 with devsel=1, with or without trdy=1; with trdy=1 that word counts as moved. After a disconnect, req stays 0 for REREQ_GAP clocks (default 2) after bus_drive falls and then rises. The address phase that follows presents the first word that was not moved.
- R6: When the last word completes, done is 1 for exactly the one clock in which bus_drive first reads 0, and no new request follows. This holds also when stop is sampled on that same edge.
- R7: stop=1 with devsel=0 in a data phase is a target abort. trdy in that phase is not counted. In the release cycle, csr_clear is 1 for exactly one clock and fatal_err rises. fatal_err then stays 1 until reset, and no request follows.
- R8: MAX_RETRY (default 3) disconnects in a row with no word moved between them are retried. The next such disconnect sets retry_tmo in its release cycle, and no request follows. A moved word or a new start clears the count.
- R9: A start pulse does not raise req while fatal_err or retry_tmo is 1, or when word_count is 0.
- R10: Whenever bus_drive is 0, frame and irdy are 0. req is never 1 while bus_drive is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-clock request to begin a burst |
| start_addr | input | ADDR_W | Byte address of the first word |
| word_count | input | CNT_W | Number of words in the burst |
| gnt | input | 1 | Bus grant from the arbiter |
| trdy | input | 1 | Target ready |
| stop | input | 1 | Target stop request |
| devsel | input | 1 | Target select |
| req | output | 1 | Bus request |
| frame | output | 1 | Frame, driven by the master |
| irdy | output | 1 | Master ready |
| bus_drive | output | 1 | Master owns and drives the bus |
| next_addr | output | ADDR_W | Address of the next word to move |
| done | output | 1 | One-clock pulse on normal completion |
| csr_clear | output | 1 | One-clock pulse to reset control/status registers |
| fatal_err | output | 1 | Sticky target-abort error |
| retry_tmo | output | 1 | Sticky retry-limit error |

## Verification
The assertions assume the arbiter raises gnt only while req is high. They also assume a target speaks only during a data phase, and that an abort comes from a target that has dropped select. The bench grants only when it reads req high. It drives trdy, stop and devsel only in cycles where frame and irdy are both high, and holds them at 0 otherwise. Random replies follow that rule: select is dropped only together with stop. A burst model in the bench turns each reply into the expected ending, release timing and resume address.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_FDROP,
    S_IDROP,
    S_REL,
    S_WAIT
  } pmt_state_e;

  typedef enum logic [1:0] {
    T_DONE,
    T_RETRY,
    T_ABORT
  } pmt_term_e;

endpackage

// File: rtl/pmt_addr_path.sv
module pmt_addr_path #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 8,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              xfer,
  output logic [ADDR_W-1:0] next_addr,
  output logic              last_word
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (load) begin
      addr_q <= start_addr;
      left_q <= word_count;
    end else if (xfer) begin
      addr_q <= addr_q + STEP;
      left_q <= left_q - ONE;
    end
  end

  assign next_addr = addr_q;
  assign last_word = (left_q == ONE);

endmodule

// File: rtl/pmt_retry_ctl.sv
module pmt_retry_ctl #(
  parameter int MAX_RETRY = 3,
  parameter int REREQ_GAP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic xfer,
  input  logic rel_retry,
  input  logic gap_tick,
  output logic at_limit,
  output logic gap_done
);

  localparam int RW = (MAX_RETRY > 1) ? $clog2(MAX_RETRY + 1) : 1;
  localparam int GW = (REREQ_GAP > 3) ? $clog2(REREQ_GAP - 1) : 1;
  localparam logic [RW-1:0] LIMIT    = RW'(MAX_RETRY);
  localparam logic [GW-1:0] GAP_LOAD = GW'(REREQ_GAP - 2);

  logic [RW-1:0] tries_q;
  logic [GW-1:0] gap_q;

  // Consecutive disconnects without progress
  always_ff @(posedge clk) begin
    if (rst || clear || xfer) begin
      tries_q <= '0;
    end else if (rel_retry && !at_limit) begin
      tries_q <= tries_q + RW'(1);
    end
  end

  // Re-request delay after releasing the bus
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
    end else if (rel_retry) begin
      gap_q <= GAP_LOAD;
    end else if (gap_tick && gap_q != '0) begin
      gap_q <= gap_q - GW'(1);
    end
  end

  assign at_limit = (tries_q == LIMIT);
  assign gap_done = (gap_q == '0);

endmodule

// File: rtl/pmt_seq.sv
module pmt_seq
  import pmt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic count_nz,
  input  logic gnt,
  input  logic trdy,
  input  logic stop,
  input  logic devsel,
  input  logic last_word,
  input  logic at_limit,
  input  logic gap_done,
  output logic load,
  output logic xfer,
  output logic rel_retry,
  output logic gap_tick,
  output logic req,
  output logic frame,
  output logic irdy,
  output logic bus_drive,
  output logic done,
  output logic csr_clear,
  output logic fatal_err,
  output logic retry_tmo
);

  pmt_state_e st_q, st_d;
  pmt_term_e  term_q, term_d;
  logic       abort_hit;

  assign load      = (st_q == S_IDLE) && start && count_nz && !fatal_err && !retry_tmo;
  assign xfer      = (st_q == S_DATA) && trdy && devsel;
  assign abort_hit = (st_q == S_DATA) && stop && !devsel;
  assign rel_retry = (st_q == S_REL) && (term_q == T_RETRY);
  assign gap_tick  = (st_q == S_WAIT);

  always_comb begin
    st_d   = st_q;
    term_d = term_q;
    case (st_q)
      S_IDLE:  if (load) st_d = S_REQ;
      S_REQ:   if (gnt) st_d = S_ADDR;
      S_ADDR:  st_d = S_DATA;
      S_DATA: begin
        if (abort_hit) begin
          st_d   = S_FDROP;
          term_d = T_ABORT;
        end else if (xfer && last_word) begin
          st_d   = S_FDROP;
          term_d = T_DONE;
        end else if (stop) begin
          st_d   = S_FDROP;
          term_d = T_RETRY;
        end
      end
      S_FDROP: st_d = S_IDROP;
      S_IDROP: st_d = S_REL;
      S_REL:   st_d = (term_q == T_RETRY && !at_limit) ? S_WAIT : S_IDLE;
      S_WAIT:  if (gap_done) st_d = S_REQ;
      default: st_d = S_IDLE;
    endcase
  end

  // Outputs are registered from the next-state decode
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      term_q    <= T_DONE;
      req       <= 1'b0;
      frame     <= 1'b0;
      irdy      <= 1'b0;
      bus_drive <= 1'b0;
      done      <= 1'b0;
      csr_clear <= 1'b0;
      fatal_err <= 1'b0;
      retry_tmo <= 1'b0;
    end else begin
      st_q      <= st_d;
      term_q    <= term_d;
      req       <= (st_d == S_REQ);
      frame     <= (st_d == S_ADDR) || (st_d == S_DATA);
      irdy      <= (st_d == S_DATA) || (st_d == S_FDROP);
      bus_drive <= (st_d == S_ADDR) || (st_d == S_DATA) ||
                   (st_d == S_FDROP) || (st_d == S_IDROP);
      done      <= (st_d == S_REL) && (term_q == T_DONE);
      csr_clear <= (st_d == S_REL) && (term_q == T_ABORT);
      fatal_err <= fatal_err || ((st_d == S_REL) && (term_q == T_ABORT));
      retry_tmo <= retry_tmo || ((st_d == S_REL) && (term_q == T_RETRY) && at_limit);
    end
  end

endmodule

// File: rtl/pmt_top.sv
module pmt_top #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 8,
  parameter int STEP_BYTES = 4,
  parameter int MAX_RETRY  = 3,
  parameter int REREQ_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              gnt,
  input  logic              trdy,
  input  logic              stop,
  input  logic              devsel,
  output logic              req,
  output logic              frame,
  output logic              irdy,
  output logic              bus_drive,
  output logic [ADDR_W-1:0] next_addr,
  output logic              done,
  output logic              csr_clear,
  output logic              fatal_err,
  output logic              retry_tmo
);

  logic load, xfer, rel_retry, gap_tick;
  logic last_word, at_limit, gap_done;

  pmt_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .count_nz  (word_count != '0),
    .gnt       (gnt),
    .trdy      (trdy),
    .stop      (stop),
    .devsel    (devsel),
    .last_word (last_word),
    .at_limit  (at_limit),
    .gap_done  (gap_done),
    .load      (load),
    .xfer      (xfer),
    .rel_retry (rel_retry),
    .gap_tick  (gap_tick),
    .req       (req),
    .frame     (frame),
    .irdy      (irdy),
    .bus_drive (bus_drive),
    .done      (done),
    .csr_clear (csr_clear),
    .fatal_err (fatal_err),
    .retry_tmo (retry_tmo)
  );

  pmt_addr_path #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .STEP_BYTES (STEP_BYTES)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .start_addr (start_addr),
    .word_count (word_count),
    .xfer       (xfer),
    .next_addr  (next_addr),
    .last_word  (last_word)
  );

  pmt_retry_ctl #(
    .MAX_RETRY (MAX_RETRY),
    .REREQ_GAP (REREQ_GAP)
  ) u_retry (
    .clk       (clk),
    .rst       (rst),
    .clear     (load),
    .xfer      (xfer),
    .rel_retry (rel_retry),
    .gap_tick  (gap_tick),
    .at_limit  (at_limit),
    .gap_done  (gap_done)
  );

endmodule

// File: rtl/pmt_chk.sv
module pmt_chk #(
  parameter int ADDR_W     = 32,
  parameter int STEP_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              frame,
  input logic              irdy,
  input logic              bus_drive,
  input logic [ADDR_W-1:0] next_addr,
  input logic              done,
  input logic              csr_clear,
  input logic              fatal_err,
  input logic              retry_tmo
);

  assert_addr_phase_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(frame) |-> (!irdy && bus_drive));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && $past(bus_drive) && next_addr != $past(next_addr))
      |-> (next_addr == $past(next_addr) + ADDR_W'(STEP_BYTES)));

  assert_frame_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(frame) |-> (irdy && bus_drive));

  assert_irdy_next_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(frame) |=> (!irdy && !frame && bus_drive));

  assert_release_after_irdy_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(irdy) |=> !bus_drive);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_clear_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    csr_clear |=> !csr_clear);

  assert_clear_with_fatal_R7: assert property (@(posedge clk) disable iff (rst)
    csr_clear |-> fatal_err);

  assert_fatal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    fatal_err |=> fatal_err);

  assert_tmo_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    retry_tmo |-> (!req && !bus_drive));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    !bus_drive |-> (!frame && !irdy));

  assert_req_not_owner_R10: assert property (@(posedge clk) disable iff (rst)
    req |-> !bus_drive);

endmodule

bind pmt_top pmt_chk #(
  .ADDR_W     (ADDR_W),
  .STEP_BYTES (STEP_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .frame     (frame),
  .irdy      (irdy),
  .bus_drive (bus_drive),
  .next_addr (next_addr),
  .done      (done),
  .csr_clear (csr_clear),
  .fatal_err (fatal_err),
  .retry_tmo (retry_tmo)
);

// File: tb/pmt_top_test.sv
module pmt_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int CNT_W      = 8;
  localparam int STEP_BYTES = 4;
  localparam int MAX_RETRY  = 3;
  localparam int REREQ_GAP  = 2;

  localparam int K_NONE  = 0;
  localparam int K_DONE  = 1;
  localparam int K_RETRY = 2;
  localparam int K_ABORT = 3;
  localparam int K_TMO   = 4;

  typedef struct packed {
    logic t;
    logic s;
    logic d;
  } rsp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  word_count = '0;
  logic              gnt = 1'b0;
  logic              trdy = 1'b0;
  logic              stop = 1'b0;
  logic              devsel = 1'b0;
  logic              req, frame, irdy, bus_drive, done, csr_clear, fatal_err, retry_tmo;
  logic [ADDR_W-1:0] next_addr;

  int   vectors = 0;
  int   miscompares = 0;
  int   cyc = 0;
  rsp_t rq[$];
  bit   rand_rsp = 1'b0;
  int   stop_pct = 20;
  int   abort_pct = 0;
  int   last_kind = K_NONE;

  pmt_top #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .STEP_BYTES (STEP_BYTES),
    .MAX_RETRY  (MAX_RETRY),
    .REREQ_GAP  (REREQ_GAP)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .word_count (word_count),
    .gnt        (gnt),
    .trdy       (trdy),
    .stop       (stop),
    .devsel     (devsel),
    .req        (req),
    .frame      (frame),
    .irdy       (irdy),
    .bus_drive  (bus_drive),
    .next_addr  (next_addr),
    .done       (done),
    .csr_clear  (csr_clear),
    .fatal_err  (fatal_err),
    .retry_tmo  (retry_tmo)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b, input int w);
    return b + ADDR_W'(STEP_BYTES * w);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    gnt = 1'b0;
    trdy = 1'b0;
    stop = 1'b0;
    devsel = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic next_rsp(output rsp_t r);
    if (rq.size() != 0) begin
      r = rq.pop_front();
    end else if (rand_rsp) begin
      r.t = 1'($urandom_range(1));
      r.s = ($urandom_range(99) < stop_pct);
      r.d = 1'b1;
      if (r.s && ($urandom_range(99) < abort_pct)) r.d = 1'b0;
    end else begin
      r = '{t: 1'b1, s: 1'b0, d: 1'b1};
    end
  endtask

  // Runs one burst against a target model and checks every ending
  task automatic run_txn(input logic [ADDR_W-1:0] a, input int n);
    int   xfers, rs, ev, kind, limit, d;
    bit   fin;
    rsp_t r;
    do_reset();
    xfers = 0; rs = 0; ev = -1; kind = K_NONE; fin = 1'b0; limit = 0;
    start_addr = a;
    word_count = CNT_W'(n);
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R2 req after start", req, 1);
    while (!fin && limit < 3000) begin
      if (ev >= 0) begin
        d = cyc - ev;
        if (d == 1) begin
          chk("R4 frame low", frame, 0);
          chk("R4 irdy held", irdy, 1);
        end
        if (d == 2) begin
          chk("R4 irdy low", irdy, 0);
          chk("R4 still driving", bus_drive, 1);
        end
        if (d == 3) begin
          chk("R4 released", bus_drive, 0);
          chk("R6 done pulse", done, kind == K_DONE);
          chk("R7 csr_clear pulse", csr_clear, kind == K_ABORT);
          chk("R7 fatal_err", fatal_err, kind == K_ABORT);
          chk("R8 retry_tmo", retry_tmo, kind == K_TMO);
        end
        if (kind == K_RETRY && d >= 3 && d < 3 + REREQ_GAP) chk("R5 req gap", req, 0);
        if (kind == K_RETRY && d == 3 + REREQ_GAP) begin
          chk("R5 re-request", req, 1);
          ev = -1;
          kind = K_NONE;
        end
        if (kind != K_RETRY && kind != K_NONE && d == 4) begin
          chk("R6 done one clock", done, 0);
          chk("R7 csr_clear one clock", csr_clear, 0);
          chk("R3 final addr", next_addr, exp_addr(a, xfers));
          chk("R10 no req after end", req, 0);
          last_kind = kind;
          fin = 1'b1;
        end
      end
      if (!bus_drive) chk("R10 idle bus", {frame, irdy}, 0);
      if (frame && !irdy) begin
        chk("R5 resume addr", next_addr, exp_addr(a, xfers));
        chk("R2 req dropped", req, 0);
      end
      gnt = req && ($urandom_range(2) != 0);
      trdy = 1'b0;
      stop = 1'b0;
      devsel = 1'b0;
      if (frame && irdy) begin
        next_rsp(r);
        trdy = r.t;
        stop = r.s;
        devsel = r.d;
        if (r.s && !r.d) begin
          kind = K_ABORT;
          ev = cyc;
        end else if (r.t && r.d) begin
          xfers++;
          rs = 0;
          if (xfers == n) begin
            kind = K_DONE;
            ev = cyc;
          end
        end
        if (kind == K_NONE && r.s && r.d) begin
          if (rs == MAX_RETRY) begin
            kind = K_TMO;
          end else begin
            rs++;
            kind = K_RETRY;
          end
          ev = cyc;
        end
      end
      step();
      limit++;
    end
    if (!fin) chk("R4 burst ended", 0, 1);
    gnt = 1'b0;
    trdy = 1'b0;
    stop = 1'b0;
    devsel = 1'b0;
  endtask

  task automatic check_start_ignored(input string tag, input int n);
    start_addr = 32'h0000_0100;
    word_count = CNT_W'(n);
    start = 1'b1;
    step();
    start = 1'b0;
    chk(tag, req, 0);
    step();
    chk(tag, req, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // Reset state
    rst = 1'b1;
    repeat (2) step();
    chk("R1 req", req, 0);
    chk("R1 bus", {frame, irdy, bus_drive}, 0);
    chk("R1 flags", {done, csr_clear, fatal_err, retry_tmo}, 0);
    do_reset();
    chk("R1 after release", {req, frame, irdy, bus_drive, done, csr_clear, fatal_err, retry_tmo}, 0);

    // Plain burst
    run_txn(32'h0000_1000, 4);
    chk("R6 plain ending", last_kind, K_DONE);

    // Wait states then completion
    rq.push_back('{t: 1'b0, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b0, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    run_txn(32'h0000_2000, 3);
    chk("R3 wait states", last_kind, K_DONE);

    // Disconnect without data after two words
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b0, s: 1'b1, d: 1'b1});
    run_txn(32'h0000_3000, 4);
    chk("R5 disconnect then done", last_kind, K_DONE);

    // Disconnect with data on the first word
    rq.push_back('{t: 1'b1, s: 1'b1, d: 1'b1});
    run_txn(32'h0000_4000, 4);
    chk("R5 disconnect with data", last_kind, K_DONE);

    // Stop together with the last word
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b1, s: 1'b1, d: 1'b1});
    run_txn(32'h0000_5000, 2);
    chk("R6 stop on last word", last_kind, K_DONE);

    // Target abort; trdy in the abort phase is not counted
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    rq.push_back('{t: 1'b1, s: 1'b1, d: 1'b0});
    run_txn(32'h0000_6000, 4);
    chk("R7 abort ending", last_kind, K_ABORT);
    chk("R7 addr after abort", next_addr, 32'h0000_6004);
    check_start_ignored("R9 start after abort", 2);
    chk("R7 fatal sticky", fatal_err, 1);

    // Retry limit
    for (int i = 0; i < MAX_RETRY + 1; i++) rq.push_back('{t: 1'b0, s: 1'b1, d: 1'b1});
    run_txn(32'h0000_7000, 4);
    chk("R8 timeout ending", last_kind, K_TMO);
    check_start_ignored("R9 start after timeout", 2);

    // Progress between disconnects clears the retry count
    for (int i = 0; i < MAX_RETRY; i++) rq.push_back('{t: 1'b0, s: 1'b1, d: 1'b1});
    rq.push_back('{t: 1'b1, s: 1'b0, d: 1'b1});
    for (int i = 0; i < MAX_RETRY; i++) rq.push_back('{t: 1'b0, s: 1'b1, d: 1'b1});
    run_txn(32'h0000_8000, 3);
    chk("R8 count cleared by progress", last_kind, K_DONE);

    // Zero-length start
    do_reset();
    check_start_ignored("R9 zero count", 0);

    // Random bursts
    rand_rsp = 1'b1;
    for (int i = 0; i < 60; i++) begin
      abort_pct = (i % 4 == 3) ? 30 : 0;
      stop_pct = 10 + (i % 3) * 10;
      run_txn({$urandom_range(32'hFFFF), 2'b00} + 32'h0001_0000, 1 + $urandom_range(9));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule